// File: doc/BRIEF.md
# Three-Pin GPIO Port with Serial Pin Takeover

This block is a small general-purpose I/O port with three pins. Software sets each pin's direction through a write-only direction register and its output value through a data register, both on a simple synchronous register bus. Reads of the data register are mixed per bit. An output pin returns its latch. An input pin returns the live level of the pin after synchronization.

Each pin can also be taken over by a serial unit. Pin 0 can carry transmit data, pin 1 can carry receive data, and pin 2 can carry a serial clock in either direction. While a takeover is enabled, the port registers have no effect on that pin.

Two standby inputs shape the pins. Hardware standby forces every pin to an input and returns both registers to their reset values. Software standby keeps both registers and turns all serial takeovers off, so that every pin simply follows its direction and data bits.

Top module: `gsp_port_top`

## Requirements
- R1: After a synchronous active-low reset, all direction bits and data latch bits are 0 and all `pad_oe` bits are 0. With all pins then switched to output, a data register read returns 0xF8.
- R2: Data register bits 7..3 always read as 1. Writes to those bits have no effect.
- R3: On a data register read (address 1), bit i returns the data latch when direction bit i is 1. It returns the synchronized level of pin i when direction bit i is 0. This rule holds even while a serial takeover owns the pin.
- R4: The direction register (address 0) is write-only and reads as 0xFF. Any address other than 0 or 1 also reads as 0xFF.
- R5: While `ser_txd_en` is 1 and neither standby is active, pin 0 has `pad_oe`=1 and drives `ser_txd_val`, whatever the register contents.
- R6: While `ser_rxd_en` is 1 and neither standby is active, pin 1 has `pad_oe`=0. `ser_rxd` always carries the synchronized level of pin 1.
- R7: While `ser_sck_en` is 1 and neither standby is active, pin 2 has `pad_oe`=`ser_sck_oe` and drives `ser_sck_val`. `ser_sck_in` carries the synchronized level of pin 2.
- R8: While `hw_standby` is 1, all `pad_oe` bits are 0 in the same cycle. Each clock edge that samples `hw_standby` high clears both registers.
- R9: While `sw_standby` is 1 (and `hw_standby` is 0), every serial takeover is off: `pad_oe` equals the direction bits and `pad_out` equals the data latch. Both registers keep their contents across standby.
- R10: A change on `pad_in` reaches the read-back path and the serial inputs after exactly two clock edges, not after one.
- R11: A write with `bus_wr`=1 and a matching `bus_addr` takes effect at the next clock edge. A write to any other address changes neither register.
- R12: With no takeover and no standby, `pad_oe` equals the direction bits and `pad_out` equals the data latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_standby | input | 1 | Hardware standby level |
| sw_standby | input | 1 | Software standby level |
| bus_addr | input | ADDR_W (4) | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W (8) | Write data |
| bus_rdata | output | DATA_W (8) | Combinational read data |
| ser_txd_en | input | 1 | Transmit takeover of pin 0 |
| ser_txd_val | input | 1 | Transmit bit value |
| ser_rxd_en | input | 1 | Receive takeover of pin 1 |
| ser_rxd | output | 1 | Synchronized pin 1 level |
| ser_sck_en | input | 1 | Clock takeover of pin 2 |
| ser_sck_oe | input | 1 | Serial clock drive enable |
| ser_sck_val | input | 1 | Serial clock output value |
| ser_sck_in | output | 1 | Synchronized pin 2 level |
| pad_in | input | NUM_PINS (3) | Raw pad levels |
| pad_oe | output | NUM_PINS (3) | Pad drive enables |
| pad_out | output | NUM_PINS (3) | Pad output values |

## Verification
The bench builds the block with its defaults: three pins, an 8-bit data path, a 4-bit address and a two-stage synchronizer. This places pin 0 on transmit, pin 1 on receive and pin 2 on the clock, so every takeover kind is exercised. The 8-bit width exposes five fixed-one upper bits for the write-ignore check. The 4-bit address leaves fourteen unmapped addresses for the 0xFF read check. The two-stage depth makes the one-edge and two-edge sampling points of R10 distinct, observable cycles.

// File: rtl/gsp_pkg.sv
// Package: shared types and address map for the serial-override GPIO port.
// Assumes exactly one alternate function kind per pin index.
package gsp_pkg;

    typedef enum logic [1:0] {
        ALT_NONE = 2'd0,
        ALT_TXD  = 2'd1,
        ALT_RXD  = 2'd2,
        ALT_SCK  = 2'd3
    } alt_kind_e;

    localparam int unsigned DIR_ADDR  = 0;
    localparam int unsigned DATA_ADDR = 1;

    // Pick the alternate function wired to a given pin index.
    function automatic alt_kind_e pin_alt(input int idx);
        case (idx)
            0:       return ALT_TXD;
            1:       return ALT_RXD;
            2:       return ALT_SCK;
            default: return ALT_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gsp_sync.sv
// Module: multi-stage synchronizer, one chain per bit.
// Assumes pad inputs are asynchronous to clk. The reset value of each stage is 0.
module gsp_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] chain_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage captures the raw pad levels.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[0] <= '0;
                else        chain_q[0] <= din;
            end
        end else begin : g_next
            // Later stages pass the level along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[s] <= '0;
                else        chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/gsp_regs.sv
// Module: direction and data registers with the read-back multiplexer.
// Assumes a synchronous write strobe and combinational reads. Hardware standby
// clears both registers like reset does.
module gsp_regs #(
    parameter int unsigned NUM_PINS = 3,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned ADDR_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hw_standby,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_sync,
    output logic [NUM_PINS-1:0] dir_q,
    output logic [NUM_PINS-1:0] dat_q
);
    import gsp_pkg::*;

    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(DIR_ADDR);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_ADDR);
    localparam int unsigned       PAD_W  = DATA_W - NUM_PINS;

    logic                clear_regs;
    logic                wr_dir;
    logic                wr_dat;
    logic [NUM_PINS-1:0] rd_bits;
    logic                unused_wbits;

    assign clear_regs   = !rst_n || hw_standby;
    assign wr_dir       = bus_wr && (bus_addr == A_DIR);
    assign wr_dat       = bus_wr && (bus_addr == A_DATA);
    assign unused_wbits = ^bus_wdata[DATA_W-1:NUM_PINS];

    // Direction register: cleared by reset or hardware standby, loaded on write.
    always_ff @(posedge clk) begin
        if (clear_regs)  dir_q <= '0;
        else if (wr_dir) dir_q <= bus_wdata[NUM_PINS-1:0];
    end

    // Data latch: cleared by reset or hardware standby, loaded on write.
    always_ff @(posedge clk) begin
        if (clear_regs)  dat_q <= '0;
        else if (wr_dat) dat_q <= bus_wdata[NUM_PINS-1:0];
    end

    // Per-bit read source: latch for outputs, synchronized pin for inputs.
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_rd
        assign rd_bits[i] = dir_q[i] ? dat_q[i] : pin_sync[i];
    end

    // Read mux: only the data register returns live bits.
    always_comb begin
        if (bus_addr == A_DATA) bus_rdata = {{PAD_W{1'b1}}, rd_bits};
        else                    bus_rdata = '1;
    end

    // R11: a direction write lands at the next edge.
    a_r11_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dir && !hw_standby) |=> (dir_q == $past(bus_wdata[NUM_PINS-1:0])));

    // R11: a data write lands at the next edge.
    a_r11_dat_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dat && !hw_standby) |=> (dat_q == $past(bus_wdata[NUM_PINS-1:0])));

    // R8: hardware standby clears both registers.
    a_r8_hw_clear: assert property (@(posedge clk) disable iff (!rst_n)
        hw_standby |=> (dir_q == '0 && dat_q == '0));

    // R11: registers hold when there is no matching write.
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && !hw_standby) |=> ($stable(dir_q) && $stable(dat_q)));

endmodule

// File: rtl/gsp_pin_mux.sv
// Module: per-pin output-enable and value selection between GPIO and serial use.
// Assumes the serial enables are cleared by software standby, and that hardware
// standby overrides everything and makes all pins inputs.
module gsp_pin_mux #(
    parameter int unsigned NUM_PINS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hw_standby,
    input  logic                sw_standby,
    input  logic [NUM_PINS-1:0] dir_q,
    input  logic [NUM_PINS-1:0] dat_q,
    input  logic                ser_txd_en,
    input  logic                ser_txd_val,
    input  logic                ser_rxd_en,
    input  logic                ser_sck_en,
    input  logic                ser_sck_oe,
    input  logic                ser_sck_val,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_out
);
    import gsp_pkg::*;

    logic alt_ok;
    logic txd_on;
    logic rxd_on;
    logic sck_on;

    // Serial takeovers only count outside both standby modes.
    assign alt_ok = !sw_standby && !hw_standby;
    assign txd_on = ser_txd_en && alt_ok;
    assign rxd_on = ser_rxd_en && alt_ok;
    assign sck_on = ser_sck_en && alt_ok;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        localparam alt_kind_e KIND = pin_alt(i);
        logic oe_sel;
        logic val_sel;

        if (KIND == ALT_TXD) begin : g_txd
            // Transmit takeover drives the pin from the serial unit.
            always_comb begin
                oe_sel  = txd_on ? 1'b1        : dir_q[i];
                val_sel = txd_on ? ser_txd_val : dat_q[i];
            end
        end else if (KIND == ALT_RXD) begin : g_rxd
            // Receive takeover turns the pin into an input.
            always_comb begin
                oe_sel  = rxd_on ? 1'b0 : dir_q[i];
                val_sel = dat_q[i];
            end
        end else if (KIND == ALT_SCK) begin : g_sck
            // Clock takeover: the serial unit chooses the direction and value.
            always_comb begin
                oe_sel  = sck_on ? ser_sck_oe  : dir_q[i];
                val_sel = sck_on ? ser_sck_val : dat_q[i];
            end
        end else begin : g_plain
            // Plain GPIO pin with no alternate use.
            always_comb begin
                oe_sel  = dir_q[i];
                val_sel = dat_q[i];
            end
        end

        assign pad_oe[i]  = oe_sel && !hw_standby;
        assign pad_out[i] = val_sel;
    end

    // R8: hardware standby makes every pin an input.
    a_r8_hw_inputs: assert property (@(posedge clk) disable iff (!rst_n)
        hw_standby |-> (pad_oe == '0));

    // R9: software standby returns every pin to its register settings.
    a_r9_sw_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_standby && !hw_standby) |-> (pad_oe == dir_q && pad_out == dat_q));

    // R5: the transmit takeover owns pin 0.
    a_r5_tx_override: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_txd_en && !sw_standby && !hw_standby) |-> (pad_oe[0] && pad_out[0] == ser_txd_val));

    // R6: the receive takeover keeps pin 1 undriven.
    a_r6_rx_input: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_rxd_en && !sw_standby && !hw_standby) |-> !pad_oe[1]);

    // R7: the clock takeover sets the pin 2 direction.
    a_r7_sck_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_sck_en && !sw_standby && !hw_standby) |-> (pad_oe[2] == ser_sck_oe));

endmodule

// File: rtl/gsp_port_top.sv
// Module: top of the three-pin GPIO port with serial pin takeover.
// Assumes pin 0 carries transmit, pin 1 receive and pin 2 the serial clock,
// and that the pads are external tristate buffers.
module gsp_port_top #(
    parameter int unsigned NUM_PINS    = 3,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hw_standby,
    input  logic                sw_standby,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                ser_txd_en,
    input  logic                ser_txd_val,
    input  logic                ser_rxd_en,
    output logic                ser_rxd,
    input  logic                ser_sck_en,
    input  logic                ser_sck_oe,
    input  logic                ser_sck_val,
    output logic                ser_sck_in,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_out
);
    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] dir_q;
    logic [NUM_PINS-1:0] dat_q;

    gsp_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pad_in),
        .dout (pin_sync)
    );

    gsp_regs #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_standby(hw_standby),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_sync  (pin_sync),
        .dir_q     (dir_q),
        .dat_q     (dat_q)
    );

    gsp_pin_mux #(.NUM_PINS(NUM_PINS)) u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_standby (hw_standby),
        .sw_standby (sw_standby),
        .dir_q      (dir_q),
        .dat_q      (dat_q),
        .ser_txd_en (ser_txd_en),
        .ser_txd_val(ser_txd_val),
        .ser_rxd_en (ser_rxd_en),
        .ser_sck_en (ser_sck_en),
        .ser_sck_oe (ser_sck_oe),
        .ser_sck_val(ser_sck_val),
        .pad_oe     (pad_oe),
        .pad_out    (pad_out)
    );

    // Synchronized serial inputs toward the serial unit (R6, R7).
    assign ser_rxd    = pin_sync[1];
    assign ser_sck_in = pin_sync[2];

endmodule

// File: tb/gsp_port_top_tb_top.sv
// Bench: vector table walk plus directed tests for the serial-override GPIO port.
module gsp_port_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_standby = 1'b0;
    logic       sw_standby = 1'b0;
    logic [3:0] bus_addr = 4'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       ser_txd_en = 1'b0, ser_txd_val = 1'b0, ser_rxd_en = 1'b0;
    logic       ser_sck_en = 1'b0, ser_sck_oe = 1'b0, ser_sck_val = 1'b0;
    logic       ser_rxd, ser_sck_in;
    logic [2:0] pad_in = 3'd0;
    logic [2:0] pad_oe, pad_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gsp_port_top dut_i (
        .clk(clk), .rst_n(rst_n), .hw_standby(hw_standby), .sw_standby(sw_standby),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ser_txd_en(ser_txd_en), .ser_txd_val(ser_txd_val), .ser_rxd_en(ser_rxd_en),
        .ser_rxd(ser_rxd), .ser_sck_en(ser_sck_en), .ser_sck_oe(ser_sck_oe),
        .ser_sck_val(ser_sck_val), .ser_sck_in(ser_sck_in),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
    );

    // {dir[2:0], dat[2:0], pad[2:0], exp_rd[7:0], exp_oe[2:0], exp_out[2:0]}
    localparam logic [22:0] VEC [6] = '{
        {3'b000, 3'b101, 3'b010, 8'hFA, 3'b000, 3'b101},
        {3'b111, 3'b101, 3'b010, 8'hFD, 3'b111, 3'b101},
        {3'b101, 3'b011, 3'b110, 8'hFB, 3'b101, 3'b011},
        {3'b010, 3'b111, 3'b000, 8'hFA, 3'b010, 3'b111},
        {3'b000, 3'b000, 3'b111, 8'hFF, 3'b000, 3'b000},
        {3'b110, 3'b001, 3'b101, 8'hF9, 3'b110, 3'b001}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [3:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 oe after reset", {5'd0, pad_oe}, 8'h00);
        wr(4'd0, 8'h07);
        rd_check("R1 data after reset", 4'd1, 8'hF8);

        // R3 R12: vector table
        foreach (VEC[k]) begin
            wr(4'd0, {5'd0, VEC[k][22:20]});
            wr(4'd1, {5'b10101, VEC[k][19:17]});
            pad_in = VEC[k][16:14];
            settle();
            rd_check("R3 read mix", 4'd1, VEC[k][13:6]);
            check("R12 oe", {5'd0, pad_oe}, {5'd0, VEC[k][5:3]});
            check("R12 out", {5'd0, pad_out}, {5'd0, VEC[k][2:0]});
        end

        // R2: upper bits fixed at 1
        wr(4'd0, 8'h07);
        wr(4'd1, 8'h00);
        rd_check("R2 upper ones", 4'd1, 8'hF8);

        // R4: direction and unmapped addresses
        rd_check("R4 dir reads ff", 4'd0, 8'hFF);
        for (int a = 2; a < 16; a++) rd_check("R4 unmapped", 4'(a), 8'hFF);

        // R11: wrong address changes nothing; timing of write
        wr(4'd5, 8'h07);
        rd_check("R11 wrong addr", 4'd1, 8'hF8);
        @(negedge clk);
        bus_addr = 4'd1; bus_wdata = 8'h03; bus_wr = 1'b1;
        #1;
        check("R11 before edge", bus_rdata, 8'hF8);
        @(negedge clk);
        bus_wr = 1'b0;
        check("R11 after edge", bus_rdata, 8'hFB);

        // R10: two-edge synchronizer delay
        wr(4'd0, 8'h00);
        pad_in = 3'b000;
        settle();
        @(negedge clk);
        pad_in = 3'b111;
        @(negedge clk);
        rd_check("R10 one edge", 4'd1, 8'hF8);
        @(negedge clk);
        rd_check("R10 two edges", 4'd1, 8'hFF);
        check("R6 rxd sync", {7'd0, ser_rxd}, 8'h01);
        check("R7 sck sync", {7'd0, ser_sck_in}, 8'h01);

        // R5: transmit takeover
        wr(4'd1, 8'h00);
        ser_txd_en = 1'b1; ser_txd_val = 1'b1;
        #1;
        check("R5 tx oe", {7'd0, pad_oe[0]}, 8'h01);
        check("R5 tx val", {7'd0, pad_out[0]}, 8'h01);
        ser_txd_val = 1'b0; #1;
        check("R5 tx val low", {7'd0, pad_out[0]}, 8'h00);

        // R6: receive takeover with direction set to output
        wr(4'd0, 8'h07);
        wr(4'd1, 8'h02);
        ser_rxd_en = 1'b1; #1;
        check("R6 rx oe", {7'd0, pad_oe[1]}, 8'h00);
        rd_check("R3 serial pin reads latch", 4'd1, 8'hFA);

        // R7: clock takeover in both directions
        wr(4'd0, 8'h00);
        ser_sck_en = 1'b1; ser_sck_oe = 1'b1; ser_sck_val = 1'b1; #1;
        check("R7 sck out oe", {7'd0, pad_oe[2]}, 8'h01);
        check("R7 sck out val", {7'd0, pad_out[2]}, 8'h01);
        ser_sck_oe = 1'b0; #1;
        check("R7 sck in oe", {7'd0, pad_oe[2]}, 8'h00);

        // R9: software standby cancels takeovers, keeps registers
        wr(4'd0, 8'h02);
        wr(4'd1, 8'h05);
        @(negedge clk);
        sw_standby = 1'b1; #1;
        check("R9 sw oe", {5'd0, pad_oe}, 8'h02);
        check("R9 sw out", {5'd0, pad_out}, 8'h05);
        repeat (2) @(negedge clk);
        sw_standby = 1'b0;
        ser_txd_en = 1'b0; ser_rxd_en = 1'b0; ser_sck_en = 1'b0;
        #1;
        check("R9 regs kept oe", {5'd0, pad_oe}, 8'h02);
        check("R9 regs kept out", {5'd0, pad_out}, 8'h05);

        // R8: hardware standby forces inputs and clears registers
        wr(4'd0, 8'h07);
        @(negedge clk);
        ser_txd_en = 1'b1;
        hw_standby = 1'b1; #1;
        check("R8 hw oe", {5'd0, pad_oe}, 8'h00);
        @(negedge clk);
        hw_standby = 1'b0; ser_txd_en = 1'b0; #1;
        check("R8 dir cleared", {5'd0, pad_oe}, 8'h00);
        wr(4'd0, 8'h07);
        rd_check("R8 data cleared", 4'd1, 8'hF8);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule